// File: doc/BRIEF.md
# Selectable-Topology Parallel Prefix Adder

This block adds two 16-bit unsigned operands and a carry-in bit without a clock. It returns a 16-bit sum and a carry-out. The carries do not ripple from bit to bit. They come from a parallel prefix network in three steps. First, each bit pair is reduced to a propagate/generate pair. Second, a tree of prefix cells merges these pairs into group pairs. Third, the sum is formed from the bit propagates and the carries that the tree produces. The carry-in takes part in the tree as an extra position below bit 0. Its propagate is tied low, so every group that reaches down to it needs only its generate term.

A compile-time parameter picks the wiring of the tree:

- **Dense logarithmic.** Every position receives its carry in the fewest cell levels.
- **Sparse.** The tree resolves only the carries at 4-bit group boundaries, and short ripple chains fill in the carries inside each group.
- **Minimal-cell.** An up-sweep/down-sweep tree that spends the fewest cells.

All three wirings must give identical results. The choice trades cell count against depth. A parameter value outside the three defined codes stops elaboration with an error.

Top module: `pfx_adder`

## Requirements
- R1: For every input, `{carry_out, sum}` equals the 17-bit sum `opnd_a + opnd_b + carry_in`.
- R2: With `TOPO` = 0 (dense logarithmic tree), the adder meets R1.
- R3: With `TOPO` = 1 (sparse tree with 4-bit ripple groups), the adder meets R1.
- R4: With `TOPO` = 2 (minimal-cell up/down-sweep tree), the adder meets R1.
- R5: The carry-in enters at the lowest position. With `opnd_b` = 0, `sum` equals `opnd_a + carry_in` modulo 2^16. With both operands 0 and `carry_in` = 1, the result is `sum` = 1 and `carry_out` = 0.
- R6: When `opnd_a ^ opnd_b` is all ones, `carry_in` travels through every position. Every `sum` bit then equals the inverse of `carry_in`, and `carry_out` equals `carry_in`.
- R7: `carry_out` is 1 whenever both operands have bit 15 set. It is 0 whenever both operands have bit 15 clear.
- R8: A carry produced in one 4-bit group reaches the groups above it. For example, `2^(4k) - 1` plus 1 gives exactly `2^(4k)` for k = 1, 2, 3, and a generate at bit i alone gives `2^(i+1)`.
- R9: Adders built with the three `TOPO` values give bit-identical `sum` and `carry_out` for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The hardest case to reach from the ports is a carry that must cross every cell level and group boundary of the tree. This happens when the carry-in meets a full-length run of propagates, or when a low-order generate must land exactly on a 4-bit boundary in the sparse wiring. Random operands almost never produce these cases. The stimulus builds them on purpose:

- operand pairs whose XOR is all ones, tried with both carry-in values;
- masks of the form `2^(4k) - 1` plus one;
- a generate walked through every bit position.

All three wirings are instantiated together and fed the same vectors, so any disagreement between them is visible on every vector.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    // Carry-tree wiring codes
    localparam int TOPO_DENSE   = 0;
    localparam int TOPO_SPARSE  = 1;
    localparam int TOPO_MINCELL = 2;

    // Span of one ripple group in the sparse wiring
    localparam int GRP_BITS = 4;

    // One prefix position: generate and propagate
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Full combining cell: keeps both group terms
    function automatic gp_t gp_black(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // Reduced cell: the lower operand already reaches the carry-in
    // position, whose propagate is zero, so the group propagate is zero
    function automatic gp_t gp_gray(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = 1'b0;
        return r;
    endfunction

    function automatic bit topo_valid(input int t);
        return (t == TOPO_DENSE) || (t == TOPO_SPARSE) || (t == TOPO_MINCELL);
    endfunction

endpackage

// File: rtl/pfx_bitgen.sv
module pfx_bitgen
    import pfx_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int NODES = WIDTH + 1
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output gp_t  [NODES-1:0] node,
    output logic [WIDTH-1:0] bit_p
);

    // Position 0 holds the carry-in as a pure generate
    assign node[0] = '{g: carry_in, p: 1'b0};

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign node[i+1] = '{g: opnd_a[i] & opnd_b[i], p: opnd_a[i] ^ opnd_b[i]};
    end

    assign bit_p = opnd_a ^ opnd_b;

endmodule

// File: rtl/pfx_ks_net.sv
// Dense logarithmic prefix network. Leaf 0 must carry a zero propagate.
module pfx_ks_net
    import pfx_pkg::*;
#(
    parameter int N = 17,
    localparam int LV = $clog2(N)
) (
    input  gp_t  [N-1:0] leaf,
    output logic [N-1:0] grp_g,
    output logic [N-1:0] grp_p
);

    gp_t [N-1:0] stg [LV+1];

    assign stg[0] = leaf;

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int SPAN = 1 << l;
        for (genvar j = 0; j < N; j++) begin : g_node
            if (j >= 2 * SPAN) begin : g_blk
                assign stg[l+1][j] = gp_black(stg[l][j], stg[l][j-SPAN]);
            end else if (j >= SPAN) begin : g_gry
                assign stg[l+1][j] = gp_gray(stg[l][j], stg[l][j-SPAN]);
            end else begin : g_pass
                assign stg[l+1][j] = stg[l][j];
            end
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        assign grp_g[j] = stg[LV][j].g;
        assign grp_p[j] = stg[LV][j].p;
    end

endmodule

// File: rtl/pfx_bk_net.sv
// Minimal-cell prefix network: up-sweep to power-of-two roots, then a
// down-sweep fills the remaining positions. Leaf 0 has zero propagate.
module pfx_bk_net
    import pfx_pkg::*;
#(
    parameter int N = 17,
    localparam int LV = $clog2(N),
    localparam int ST = 2 * LV - 1
) (
    input  gp_t  [N-1:0] leaf,
    output logic [N-1:0] grp_g,
    output logic [N-1:0] grp_p
);

    gp_t [N-1:0] stg [ST+1];

    assign stg[0] = leaf;

    for (genvar s = 0; s < ST; s++) begin : g_stage
        localparam bit UP   = (s < LV);
        localparam int LVL  = UP ? s : (2 * LV - 2 - s);
        localparam int SPAN = 1 << LVL;
        for (genvar j = 0; j < N; j++) begin : g_node
            if (UP && ((j + 1) % (2 * SPAN) == 0)) begin : g_up
                if (j == 2 * SPAN - 1) begin : g_gry
                    assign stg[s+1][j] = gp_gray(stg[s][j], stg[s][j-SPAN]);
                end else begin : g_blk
                    assign stg[s+1][j] = gp_black(stg[s][j], stg[s][j-SPAN]);
                end
            end else if (!UP && ((j + 1) % (2 * SPAN) == SPAN) && (j >= 2 * SPAN)) begin : g_dn
                assign stg[s+1][j] = gp_gray(stg[s][j], stg[s][j-SPAN]);
            end else begin : g_pass
                assign stg[s+1][j] = stg[s][j];
            end
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        assign grp_g[j] = stg[ST][j].g;
        assign grp_p[j] = stg[ST][j].p;
    end

endmodule

// File: rtl/pfx_carry_tree.sv
// carry[i] is the carry into bit i; carry[WIDTH] is the carry out.
module pfx_carry_tree
    import pfx_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int TOPO  = TOPO_DENSE,
    localparam int NODES = WIDTH + 1
) (
    input  gp_t  [NODES-1:0] node,
    output logic [WIDTH:0]   carry
);

    if (!topo_valid(TOPO)) begin : g_bad_topo
        $error("pfx_carry_tree: TOPO %0d selects no carry tree", TOPO);
    end

    if (TOPO == TOPO_DENSE) begin : g_dense
        logic [NODES-1:0] p_unused;
        pfx_ks_net #(.N(NODES)) u_net (
            .leaf  (node),
            .grp_g (carry),
            .grp_p (p_unused)
        );
    end else if (TOPO == TOPO_MINCELL) begin : g_mincell
        logic [NODES-1:0] p_unused;
        pfx_bk_net #(.N(NODES)) u_net (
            .leaf  (node),
            .grp_g (carry),
            .grp_p (p_unused)
        );
    end else if (TOPO == TOPO_SPARSE) begin : g_sparse
        localparam int NGRP = WIDTH / GRP_BITS;

        if (WIDTH % GRP_BITS != 0) begin : g_bad_width
            $error("pfx_carry_tree: WIDTH %0d not a multiple of %0d", WIDTH, GRP_BITS);
        end

        gp_t  [NGRP:0] blk;
        logic [NGRP:0] blk_c;
        logic [NGRP:0] p_unused;

        assign blk[0] = node[0];

        // Fold each group's bit pairs into one block pair
        for (genvar k = 0; k < NGRP; k++) begin : g_grp
            localparam int LO = k * GRP_BITS + 1;
            gp_t [GRP_BITS-1:0] fold;
            assign fold[0] = node[LO];
            for (genvar i = 1; i < GRP_BITS; i++) begin : g_fold
                assign fold[i] = gp_black(node[LO+i], fold[i-1]);
            end
            assign blk[k+1] = fold[GRP_BITS-1];
        end

        // Prefix tree over block pairs gives every boundary carry
        pfx_ks_net #(.N(NGRP + 1)) u_net (
            .leaf  (blk),
            .grp_g (blk_c),
            .grp_p (p_unused)
        );

        for (genvar k = 0; k <= NGRP; k++) begin : g_bnd
            assign carry[k*GRP_BITS] = blk_c[k];
        end

        // Short ripple fills the carries inside each group
        for (genvar k = 0; k < NGRP; k++) begin : g_rip
            for (genvar i = 0; i < GRP_BITS - 1; i++) begin : g_bit
                localparam int B = k * GRP_BITS + i;
                assign carry[B+1] = node[B+1].g | (node[B+1].p & carry[B]);
            end
        end
    end

endmodule

// File: rtl/pfx_adder.sv
module pfx_adder
    import pfx_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int TOPO  = TOPO_DENSE
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    localparam int NODES = WIDTH + 1;

    gp_t  [NODES-1:0] node;
    logic [WIDTH-1:0] bit_p;
    logic [WIDTH:0]   carry;

    pfx_bitgen #(.WIDTH(WIDTH)) u_bitgen (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .carry_in (carry_in),
        .node     (node),
        .bit_p    (bit_p)
    );

    pfx_carry_tree #(.WIDTH(WIDTH), .TOPO(TOPO)) u_tree (
        .node  (node),
        .carry (carry)
    );

    assign sum       = bit_p ^ carry[WIDTH-1:0];
    assign carry_out = carry[WIDTH];

endmodule

// File: rtl/pfx_adder_chk.sv
module pfx_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out
);

    always_comb begin
        // R1: full 17-bit result
        p_total_r1: assert ({carry_out, sum} ==
                            ({1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in}));
        // R5: carry-in only
        if (opnd_b == '0) begin
            p_cin_add_r5: assert (sum == opnd_a + WIDTH'(carry_in));
        end
        // R6: full propagate run
        if ((opnd_a ^ opnd_b) == {WIDTH{1'b1}}) begin
            p_chain_r6: assert ((carry_out == carry_in) && (sum == {WIDTH{~carry_in}}));
        end
        // R7: top-bit generate and kill
        if (opnd_a[WIDTH-1] && opnd_b[WIDTH-1]) begin
            p_top_gen_r7: assert (carry_out);
        end
        if (!opnd_a[WIDTH-1] && !opnd_b[WIDTH-1]) begin
            p_top_kill_r7: assert (!carry_out);
        end
    end

endmodule

bind pfx_adder pfx_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/tb_pfx_adder.sv
module tb_pfx_adder;

    localparam int W = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic         rst;
    logic [W-1:0] a, b;
    logic         ci;
    logic [W-1:0] s_dn, s_sp, s_mc;
    logic         co_dn, co_sp, co_mc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pfx_adder #(.WIDTH(W), .TOPO(0)) dut (
        .opnd_a(a), .opnd_b(b), .carry_in(ci), .sum(s_dn), .carry_out(co_dn));
    pfx_adder #(.WIDTH(W), .TOPO(1)) dut_sp (
        .opnd_a(a), .opnd_b(b), .carry_in(ci), .sum(s_sp), .carry_out(co_sp));
    pfx_adder #(.WIDTH(W), .TOPO(2)) dut_mc (
        .opnd_a(a), .opnd_b(b), .carry_in(ci), .sum(s_mc), .carry_out(co_mc));

    task automatic cmp(input string req, input string tag, input logic [W:0] got,
                       input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%h exp=%h", req, tag, got, exp);
        end
    endtask

    // Apply one vector away from the clock edge and check all three trees
    task automatic run_vec(input logic [W-1:0] va, input logic [W-1:0] vb,
                           input logic vc, input logic [W:0] exp, input string req);
        @(negedge clk);
        a = va; b = vb; ci = vc;
        #1;
        cmp(req, "R2 dense",   {co_dn, s_dn}, exp);
        cmp(req, "R3 sparse",  {co_sp, s_sp}, exp);
        cmp(req, "R4 mincell", {co_mc, s_mc}, exp);
        checks++;
        if (({co_dn, s_dn} !== {co_sp, s_sp}) || ({co_dn, s_dn} !== {co_mc, s_mc})) begin
            errors++;
            $display("FAIL R9 trees differ got=%h/%h/%h exp=equal",
                     {co_dn, s_dn}, {co_sp, s_sp}, {co_mc, s_mc});
        end
    endtask

    task automatic t_reset;
        run_vec(16'h0000, 16'h0000, 1'b0, 17'h00000, "R1 idle");
    endtask

    task automatic t_cin;
        run_vec(16'h0000, 16'h0000, 1'b1, 17'h00001, "R5 cin only");
        run_vec(16'h1234, 16'h0000, 1'b1, 17'h01235, "R5 a plus cin");
        run_vec(16'hFFFE, 16'h0000, 1'b1, 17'h0FFFF, "R5 near top");
    endtask

    task automatic t_chain;
        run_vec(16'hFFFF, 16'h0000, 1'b1, 17'h10000, "R6 ones plus cin");
        run_vec(16'h5555, 16'hAAAA, 1'b1, 17'h10000, "R6 alt plus cin");
        run_vec(16'h5555, 16'hAAAA, 1'b0, 17'h0FFFF, "R6 alt no cin");
        run_vec(16'h0000, 16'hFFFF, 1'b0, 17'h0FFFF, "R6 b ones");
    endtask

    task automatic t_top;
        run_vec(16'h8000, 16'h8000, 1'b0, 17'h10000, "R7 top gen");
        run_vec(16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, "R7 all ones cin");
        run_vec(16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE, "R7 all ones");
        run_vec(16'h7FFF, 16'h7FFF, 1'b1, 17'h0FFFF, "R7 top kill");
    endtask

    task automatic t_group;
        run_vec(16'h000F, 16'h0001, 1'b0, 17'h00010, "R8 boundary 4");
        run_vec(16'h00FF, 16'h0001, 1'b0, 17'h00100, "R8 boundary 8");
        run_vec(16'h0FFF, 16'h0001, 1'b0, 17'h01000, "R8 boundary 12");
        run_vec(16'h0007, 16'h0008, 1'b1, 17'h00010, "R8 cin to boundary");
        run_vec(16'h00F0, 16'h0010, 1'b0, 17'h00100, "R8 mid group");
        run_vec(16'hF000, 16'h1000, 1'b0, 17'h10000, "R8 top group");
        run_vec(16'h0F0F, 16'h00F1, 1'b0, 17'h01000, "R8 mixed groups");
        for (int i = 0; i < W; i++) begin
            run_vec(W'(1) << i, W'(1) << i, 1'b0, 17'h00001 << (i + 1), "R8 walking gen");
        end
    endtask

    task automatic t_alt;
        run_vec(16'hA5A5, 16'h5A5A, 1'b0, 17'h0FFFF, "R1 checker no cin");
        run_vec(16'hA5A5, 16'h5A5A, 1'b1, 17'h10000, "R1 checker cin");
        run_vec(16'h1234, 16'h4321, 1'b0, 17'h05555, "R1 mixed");
        run_vec(16'hAAAA, 16'hAAAA, 1'b0, 17'h15554, "R1 double alt");
        run_vec(16'h5555, 16'h5555, 1'b1, 17'h0AAAB, "R1 double alt cin");
    endtask

    task automatic t_random;
        logic [31:0] st;
        logic [W:0]  exp;
        st = 32'h1ACE_B00C;
        for (int n = 0; n < 400; n++) begin
            st = st ^ (st << 13);
            st = st ^ (st >> 17);
            st = st ^ (st << 5);
            exp = {1'b0, st[15:0]} + {1'b0, st[31:16]} + {{W{1'b0}}, st[7]};
            run_vec(st[15:0], st[31:16], st[7], exp, "R9 random");
        end
    endtask

    initial begin
        a   = '0;
        b   = '0;
        ci  = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset;
        t_cin;
        t_chain;
        t_top;
        t_group;
        t_alt;
        t_random;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog rst=%0b got=timeout exp=finish", rst);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule